// File: doc/BRIEF.md
# I2S Error Status and Interrupt Unit

This block sits beside the serial shifter, the transmit FIFO and the receive DMA channel of an I2S audio port. It watches their events and records five kinds of fault: a receive DMA block that moves more words than it should, frame-sync timing faults in slave operation, a transmit FIFO that is empty when a frame begins, a transmit FIFO that runs empty partway through a frame, and writes to a full transmit FIFO. Each fault sets a sticky flag in one status word. The block drives a single interrupt that is the OR of the flags whose mask bit is 0.

The block also sits on the FIFO strobes. It passes the shifter's word requests on as FIFO reads. After a frame-start underflow it blocks those reads until the next frame sync. It passes CPU writes on to the FIFO, but drops any write that arrives while the FIFO is full. When the block-size fault is set, the block holds a stop request to the receive DMA channel.

Software clears the timing, underflow and overflow flags by writing 1 to their bits over a simple write port. A software reset pulse clears every flag and every internal counter.

Top module: `i2s_err_unit`

## Requirements
- R1: After reset, `status`, `irq`, `rx_dma_stop`, `tx_fifo_rd` and `tx_fifo_wr` are all 0. The `status` layout is: bit 0 receive block-size fault, bit 1 frame timing fault, bit 2 frame-start underflow, bit 3 mid-frame underflow, bit 4 transmit overflow. A flag becomes visible in the cycle after the event that sets it.
- R2: If `tx_wr` is high while `tx_full` is high, bit 4 is set and `tx_fifo_wr` stays low in that cycle. If `tx_wr` is high while the FIFO is not full, `tx_fifo_wr` follows it.
- R3: The first `tx_word_req` of a frame is the first one at or after a `fs_pulse`; a request in the same cycle as `fs_pulse` counts as first. If `tx_empty` is high on that request, bit 2 is set and no read is issued.
- R4: After a frame-start underflow, `tx_fifo_rd` stays low for every request until the next `fs_pulse`, and bit 3 cannot be set in that frame.
- R5: A later request in a frame with `tx_empty` high sets bit 3 and issues no read. With `tx_empty` low, `tx_fifo_rd` follows the request.
- R6: If the FIFO ran empty mid-frame and is still empty at the first request of the next frame, bits 3 and 2 are both set.
- R7: With `cfg_slave`=1 and `cfg_free_run`=1, once a frame sync has been seen, a sync is due on the `cfg_frame_len`-th `bit_tick` after the previous sync. A due tick without `fs_pulse` sets bit 1. Ticks before the first sync raise no fault.
- R8: With `cfg_slave`=1 and `cfg_free_run`=0, an `fs_pulse` while `frm_active` is high sets bit 1. A sync while idle, or a long gap between syncs, does not set it.
- R9: With `cfg_slave`=0, bit 1 is never set.
- R10: While `rx_dma_act` is high, each `rx_xfer` counts one word of the current block, and `rx_blk_done` restarts the count. The word that makes the count exceed `cfg_rx_thr`+1 sets bit 0. `rx_dma_stop` equals bit 0. Transfers while `rx_dma_act` is low are not counted.
- R11: A `clr_we` cycle clears each of bits 1 to 4 whose `clr_data` bit is 1. Writing 0 has no effect. Bit 0 cannot be cleared this way.
- R12: If a flag's set event and its write-1 clear fall in the same cycle, the flag ends up set.
- R13: `sw_rst` clears all five flags and the receive word count. It takes priority over any set event.
- R14: `irq` is 1 exactly when some bit of `status & ~irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset pulse, clears flags and counters |
| cfg_slave | input | 1 | 1 = port is frame-sync slave |
| cfg_free_run | input | 1 | 1 = free-running slave, rate check; 0 = frame-triggered |
| cfg_frame_len | input | FL_W | Frame length in bit clocks (at least 1) |
| cfg_rx_thr | input | RC_W | Receive block threshold; block holds thr+1 words |
| fs_pulse | input | 1 | Frame sync event from the serial engine |
| bit_tick | input | 1 | One bit-clock period elapsed |
| frm_active | input | 1 | Serial engine is shifting frame words |
| tx_word_req | input | 1 | Shifter asks for the next transmit word |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_wr | input | 1 | CPU write strobe toward the transmit FIFO |
| tx_fifo_rd | output | 1 | Gated read strobe to the transmit FIFO |
| tx_fifo_wr | output | 1 | Gated write strobe to the transmit FIFO |
| rx_dma_act | input | 1 | Receive DMA channel enabled |
| rx_xfer | input | 1 | One word moved by the receive DMA channel |
| rx_blk_done | input | 1 | Receive DMA block boundary |
| rx_dma_stop | output | 1 | Stop request to the receive DMA channel |
| irq_mask | input | 5 | Per-flag mask, 1 = masked |
| clr_we | input | 1 | Flag-clear write strobe |
| clr_data | input | 5 | Write-1-to-clear data, same layout as status |
| status | output | 5 | Sticky flag word |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the receive threshold against every block length around the limit. A counter that is off by one would flag a legal block of thr+1 words, or let thr+2 words through. It sweeps the frame length in free-running slave mode and checks the tick just before the due sync and the due tick itself. This catches a reload value that is one off, and a check that also fires in triggered or master mode. In frame-start underflow cases it looks for reads that leak out later in the same frame, and for a mid-frame flag raised in that frame, both of which a design that does not block reads would show. It also tests set-versus-clear collisions, clears of the block-size flag that must not take effect, and all 32 mask values. A design that lets the clear win, or that builds the interrupt from the wrong bits, fails these checks.

// File: rtl/i2s_err_pkg.sv
// Package: flag positions and helper types for the I2S error unit.
// Assumes a five-flag status word; positions are the software-visible layout.
package i2s_err_pkg;
    localparam int NFLAG        = 5;
    localparam int FL_RXBLK     = 0;
    localparam int FL_FRAME     = 1;
    localparam int FL_UFL_START = 2;
    localparam int FL_UFL_MID   = 3;
    localparam int FL_OVF       = 4;
    // bits that a write-1 may clear
    localparam logic [NFLAG-1:0] W1C_MASK = 5'b11110;
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/i2s_err_rxblk.sv
// Module: counts receive DMA words per block and pulses an error when the
// count passes thr+1. Assumes rx_xfer is one pulse per word; the counter
// saturates, so a threshold at the counter maximum never trips.
module i2s_err_rxblk #(
    parameter int RC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_rst,
    input  logic            act,
    input  logic            xfer,
    input  logic            blk_done,
    input  logic [RC_W-1:0] thr,
    output logic            err_set
);
    localparam logic [RC_W-1:0] CNT_MAX = {RC_W{1'b1}};

    logic [RC_W-1:0] wcnt;
    logic            count_en;

    // Purpose: qualify a counted word.
    always_comb count_en = act && xfer;

    // Purpose: word count within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
            wcnt <= '0;
        else if (blk_done)
            wcnt <= '0;
        else if (count_en && wcnt != CNT_MAX)
            wcnt <= wcnt + 1'b1;
    end

    // Purpose: this word is number wcnt+1; fault when it exceeds thr+1.
    always_comb err_set = count_en && (wcnt > thr);
endmodule

// File: rtl/i2s_err_frame.sv
// Module: frame-sync timing checker for slave operation.
// Free-running: a down-counter is reloaded with len-1 at each sync and counts
// bit ticks; a tick at zero with no sync is a fault. Triggered: a sync while
// the engine is still shifting is a fault. Assumes len >= 1 and that a sync
// which arrives on time comes with its bit tick.
module i2s_err_frame #(
    parameter int FL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_rst,
    input  logic            slave,
    input  logic            free_run,
    input  logic [FL_W-1:0] frame_len,
    input  logic            fs,
    input  logic            tick,
    input  logic            active,
    output logic            err_set
);
    logic [FL_W-1:0] rem;
    logic            armed;
    logic [FL_W-1:0] reload;
    logic            late_err;
    logic            early_err;

    // Purpose: reload value, guarded against a zero length.
    always_comb reload = (frame_len == '0) ? '0 : frame_len - 1'b1;

    // Purpose: detect a due tick with no sync and a sync during an active frame.
    always_comb begin
        late_err  = slave && free_run && armed && tick && !fs && (rem == '0);
        early_err = slave && !free_run && fs && active;
        err_set   = late_err || early_err;
    end

    // Purpose: bit-tick distance to the next expected sync.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            rem   <= '0;
            armed <= 1'b0;
        end else if (fs) begin
            rem   <= reload;
            armed <= 1'b1;
        end else if (late_err) begin
            armed <= 1'b0;
        end else if (tick && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end
endmodule

// File: rtl/i2s_err_txmon.sv
// Module: gates transmit FIFO strobes and spots underflow and overflow.
// The first word request at or after a sync is the frame-start read; an
// empty FIFO there blocks reads until the next sync. Assumes tx_empty and
// tx_full are valid in the cycle of the strobe.
module i2s_err_txmon (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic fs,
    input  logic word_req,
    input  logic empty,
    input  logic full,
    input  logic wr,
    output logic fifo_rd,
    output logic fifo_wr,
    output logic start_ufl,
    output logic mid_ufl,
    output logic ovf
);
    logic start_pend;
    logic rd_block;
    logic req_first;
    logic req_mid;

    // Purpose: classify the request and derive strobes and fault pulses.
    always_comb begin
        req_first = word_req && (fs || start_pend);
        req_mid   = word_req && !(fs || start_pend) && !rd_block;
        start_ufl = req_first && empty;
        mid_ufl   = req_mid && empty;
        fifo_rd   = (req_first || req_mid) && !empty;
        ovf       = wr && full;
        fifo_wr   = wr && !full;
    end

    // Purpose: remember a pending first read and a frame-long read block.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            start_pend <= 1'b0;
            rd_block   <= 1'b0;
        end else begin
            if (fs)
                start_pend <= !word_req;
            else if (word_req)
                start_pend <= 1'b0;
            if (start_ufl)
                rd_block <= 1'b1;
            else if (fs)
                rd_block <= 1'b0;
        end
    end
endmodule

// File: rtl/i2s_err_flags.sv
// Module: bank of sticky flags. Software reset clears all; a write-1 clears
// a bit only where W1C allows; a set event in the same cycle wins.
module i2s_err_flags #(
    parameter int               N   = 5,
    parameter logic [N-1:0]     W1C = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_data,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr_i;
        // Purpose: a clear request for this bit.
        always_comb clr_i = clr_we && clr_data[i] && W1C[i];
        // Purpose: sticky bit with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr_i)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2s_err_unit.sv
// Module: top of the I2S error status and interrupt unit. Wires the receive
// block checker, the frame timing checker and the transmit monitor into the
// sticky flag bank and builds the masked interrupt and the DMA stop.
module i2s_err_unit
    import i2s_err_pkg::*;
#(
    parameter int FL_W = 8,
    parameter int RC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             cfg_slave,
    input  logic             cfg_free_run,
    input  logic [FL_W-1:0]  cfg_frame_len,
    input  logic [RC_W-1:0]  cfg_rx_thr,
    input  logic             fs_pulse,
    input  logic             bit_tick,
    input  logic             frm_active,
    input  logic             tx_word_req,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             tx_wr,
    output logic             tx_fifo_rd,
    output logic             tx_fifo_wr,
    input  logic             rx_dma_act,
    input  logic             rx_xfer,
    input  logic             rx_blk_done,
    output logic             rx_dma_stop,
    input  logic [NFLAG-1:0] irq_mask,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_data,
    output logic [NFLAG-1:0] status,
    output logic             irq
);
    logic      rxblk_set;
    logic      frame_set;
    logic      ufl_start_set;
    logic      ufl_mid_set;
    logic      ovf_set;
    flag_vec_t set_vec;

    i2s_err_rxblk #(.RC_W(RC_W)) u_rxblk (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .act(rx_dma_act), .xfer(rx_xfer), .blk_done(rx_blk_done),
        .thr(cfg_rx_thr), .err_set(rxblk_set)
    );

    i2s_err_frame #(.FL_W(FL_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .slave(cfg_slave), .free_run(cfg_free_run), .frame_len(cfg_frame_len),
        .fs(fs_pulse), .tick(bit_tick), .active(frm_active),
        .err_set(frame_set)
    );

    i2s_err_txmon u_txmon (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .fs(fs_pulse), .word_req(tx_word_req), .empty(tx_empty),
        .full(tx_full), .wr(tx_wr),
        .fifo_rd(tx_fifo_rd), .fifo_wr(tx_fifo_wr),
        .start_ufl(ufl_start_set), .mid_ufl(ufl_mid_set), .ovf(ovf_set)
    );

    // Purpose: gather set pulses into status layout.
    always_comb begin
        set_vec               = '0;
        set_vec[FL_RXBLK]     = rxblk_set;
        set_vec[FL_FRAME]     = frame_set;
        set_vec[FL_UFL_START] = ufl_start_set;
        set_vec[FL_UFL_MID]   = ufl_mid_set;
        set_vec[FL_OVF]       = ovf_set;
    end

    i2s_err_flags #(.N(NFLAG), .W1C(W1C_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .set(set_vec), .clr_we(clr_we), .clr_data(clr_data),
        .flags(status)
    );

    // Purpose: masked interrupt and DMA stop request.
    always_comb begin
        irq         = |(status & ~irq_mask);
        rx_dma_stop = status[FL_RXBLK];
    end
endmodule

// File: rtl/i2s_err_unit_chk.sv
// Module: assertion checker for i2s_err_unit, attached by bind below.
module i2s_err_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       tx_wr,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       tx_fifo_rd,
    input logic       tx_fifo_wr,
    input logic       rx_dma_stop,
    input logic [4:0] irq_mask,
    input logic [4:0] status,
    input logic       irq
);
    AST_OVF_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full) |-> !tx_fifo_wr); // R2
    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rd |-> !tx_empty); // R4
    AST_STOP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_stop == status[0]); // R10
    AST_RXBLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !sw_rst) |=> status[0]); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !sw_rst) |=> status[4]); // R12
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (status == 5'b0)); // R13
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~irq_mask) == 5'b0) |-> !irq); // R14
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~irq_mask) != 5'b0) |-> irq); // R14
endmodule

bind i2s_err_unit i2s_err_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .tx_wr(tx_wr), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_fifo_rd(tx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
    .rx_dma_stop(rx_dma_stop), .irq_mask(irq_mask),
    .status(status), .irq(irq)
);

// File: tb/i2s_err_unit_tb.sv
module i2s_err_unit_tb;
    localparam int FL_W = 6;
    localparam int RC_W = 4;

    logic            clk = 1'b0;
    logic            rst_n, sw_rst, cfg_slave, cfg_free_run;
    logic [FL_W-1:0] cfg_frame_len;
    logic [RC_W-1:0] cfg_rx_thr;
    logic            fs_pulse, bit_tick, frm_active, tx_word_req;
    logic            tx_empty, tx_full, tx_wr, tx_fifo_rd, tx_fifo_wr;
    logic            rx_dma_act, rx_xfer, rx_blk_done, rx_dma_stop;
    logic [4:0]      irq_mask, clr_data, status;
    logic            clr_we, irq;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2s_err_unit #(.FL_W(FL_W), .RC_W(RC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .cfg_slave(cfg_slave), .cfg_free_run(cfg_free_run),
        .cfg_frame_len(cfg_frame_len), .cfg_rx_thr(cfg_rx_thr),
        .fs_pulse(fs_pulse), .bit_tick(bit_tick), .frm_active(frm_active),
        .tx_word_req(tx_word_req), .tx_empty(tx_empty), .tx_full(tx_full),
        .tx_wr(tx_wr), .tx_fifo_rd(tx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
        .rx_dma_act(rx_dma_act), .rx_xfer(rx_xfer), .rx_blk_done(rx_blk_done),
        .rx_dma_stop(rx_dma_stop), .irq_mask(irq_mask), .clr_we(clr_we),
        .clr_data(clr_data), .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic srst();
        sw_rst = 1'b1; cyc(); sw_rst = 1'b0;
    endtask

    task automatic xfers(input int n);
        for (int i = 0; i < n; i++) begin
            rx_xfer = 1'b1; cyc(); rx_xfer = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
        end
    endtask

    // drive events that set all five flags; status must then be 5'h1F
    task automatic set_all();
        srst();
        cfg_slave = 1'b1; cfg_free_run = 1'b0;
        rx_dma_act = 1'b1; cfg_rx_thr = '0; xfers(2); rx_dma_act = 1'b0;
        frm_active = 1'b1; fs_pulse = 1'b1; tx_word_req = 1'b1; tx_empty = 1'b1;
        cyc();
        frm_active = 1'b0; tx_empty = 1'b0; cyc();
        fs_pulse = 1'b0; tx_empty = 1'b1; cyc();
        tx_word_req = 1'b0; tx_empty = 1'b0;
        tx_full = 1'b1; tx_wr = 1'b1; cyc();
        tx_full = 1'b0; tx_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; cfg_slave = 1'b1; cfg_free_run = 1'b0;
        cfg_frame_len = 6'd4; cfg_rx_thr = 4'd2; fs_pulse = 1'b0;
        bit_tick = 1'b0; frm_active = 1'b0; tx_word_req = 1'b0;
        tx_empty = 1'b0; tx_full = 1'b0; tx_wr = 1'b0; rx_dma_act = 1'b0;
        rx_xfer = 1'b0; rx_blk_done = 1'b0; irq_mask = 5'h00;
        clr_we = 1'b0; clr_data = 5'h00;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 stop", int'(rx_dma_stop), 0);
        chk("R1 rd", int'(tx_fifo_rd), 0);
        chk("R1 wr", int'(tx_fifo_wr), 0);

        // R10 sweep: threshold vs block length
        rx_dma_act = 1'b1;
        for (int thr = 0; thr <= 5; thr++) begin
            for (int n = 1; n <= thr + 3; n++) begin
                srst();
                cfg_rx_thr = thr[RC_W-1:0];
                xfers(n);
                chk("R10 blk flag", int'(status[0]), (n > thr + 1) ? 1 : 0);
                chk("R10 stop", int'(rx_dma_stop), (n > thr + 1) ? 1 : 0);
            end
        end
        // R10 block boundary restarts the count
        srst(); cfg_rx_thr = 4'd2;
        xfers(3);
        rx_blk_done = 1'b1; cyc(); rx_blk_done = 1'b0;
        xfers(3);
        chk("R10 after boundary", int'(status[0]), 0);
        xfers(1);
        chk("R10 overrun after boundary", int'(status[0]), 1);
        // R13 software reset clears the flag and the word count
        srst();
        chk("R13 rx flag cleared", int'(status[0]), 0);
        chk("R13 stop cleared", int'(rx_dma_stop), 0);
        xfers(3); srst(); xfers(1);
        chk("R13 count cleared", int'(status[0]), 0);
        // R10 inactive channel ignores transfers
        srst(); rx_dma_act = 1'b0; cfg_rx_thr = 4'd0;
        xfers(8);
        chk("R10 inactive", int'(status[0]), 0);

        // R7 free-running slave rate sweep
        cfg_slave = 1'b1; cfg_free_run = 1'b1;
        srst(); ticks(10);
        chk("R7 no sync yet", int'(status[1]), 0);
        for (int len = 2; len <= 6; len++) begin
            srst();
            cfg_frame_len = len[FL_W-1:0];
            fs_pulse = 1'b1; bit_tick = 1'b1; cyc(); fs_pulse = 1'b0; bit_tick = 1'b0;
            ticks(len - 1);
            chk("R7 before due tick", int'(status[1]), 0);
            fs_pulse = 1'b1; bit_tick = 1'b1; cyc(); fs_pulse = 1'b0; bit_tick = 1'b0;
            ticks(len - 1);
            chk("R7 on-time frame", int'(status[1]), 0);
            ticks(1);
            chk("R7 missing sync", int'(status[1]), 1);
        end

        // R8 triggered slave
        cfg_free_run = 1'b0;
        srst(); frm_active = 1'b1;
        fs_pulse = 1'b1; cyc(); fs_pulse = 1'b0;
        chk("R8 sync while active", int'(status[1]), 1);
        srst(); frm_active = 1'b0;
        fs_pulse = 1'b1; cyc(); fs_pulse = 1'b0;
        ticks(20);
        chk("R8 idle sync and gap", int'(status[1]), 0);

        // R9 master mode never flags
        cfg_slave = 1'b0;
        for (int fr = 0; fr <= 1; fr++) begin
            cfg_free_run = fr[0];
            srst(); cfg_frame_len = 6'd3;
            fs_pulse = 1'b1; bit_tick = 1'b1; cyc(); fs_pulse = 1'b0; bit_tick = 1'b0;
            ticks(12);
            frm_active = 1'b1; fs_pulse = 1'b1; cyc(); fs_pulse = 1'b0; frm_active = 1'b0;
            chk("R9 master", int'(status[1]), 0);
        end
        cfg_slave = 1'b1; cfg_free_run = 1'b0;

        // R3 / R4 frame-start underflow, same-cycle sync and request
        srst();
        tx_empty = 1'b1; fs_pulse = 1'b1; tx_word_req = 1'b1;
        #1 chk("R3 no read on empty start", int'(tx_fifo_rd), 0);
        cyc(); fs_pulse = 1'b0;
        chk("R3 start flag", int'(status[2]), 1);
        repeat (3) cyc();
        chk("R4 no mid flag in blocked frame", int'(status[3]), 0);
        tx_empty = 1'b0;
        #1 chk("R4 read blocked", int'(tx_fifo_rd), 0);
        cyc();
        fs_pulse = 1'b1;
        #1 chk("R4 reads resume next frame", int'(tx_fifo_rd), 1);
        cyc(); fs_pulse = 1'b0; tx_word_req = 1'b0;
        chk("R4 mid flag still clear", int'(status[3]), 0);
        // R3 first request one cycle after the sync
        srst();
        fs_pulse = 1'b1; cyc(); fs_pulse = 1'b0;
        tx_empty = 1'b1; tx_word_req = 1'b1; cyc(); tx_word_req = 1'b0; tx_empty = 1'b0;
        chk("R3 deferred first request", int'(status[3:2]), 1);

        // R5 / R6 mid-frame underflow then empty at next start
        srst();
        fs_pulse = 1'b1; tx_word_req = 1'b1; cyc(); fs_pulse = 1'b0;
        #1 chk("R5 mid read passes", int'(tx_fifo_rd), 1);
        cyc();
        tx_empty = 1'b1;
        #1 chk("R5 no read on empty", int'(tx_fifo_rd), 0);
        cyc();
        chk("R5 mid flag only", int'(status[3:2]), 2);
        fs_pulse = 1'b1; cyc(); fs_pulse = 1'b0; tx_word_req = 1'b0; tx_empty = 1'b0;
        chk("R6 both underflow flags", int'(status[3:2]), 3);

        // R2 overflow and discard
        srst();
        tx_full = 1'b1; tx_wr = 1'b1;
        #1 chk("R2 write dropped", int'(tx_fifo_wr), 0);
        cyc();
        chk("R2 overflow flag", int'(status[4]), 1);
        tx_full = 1'b0;
        #1 chk("R2 write passes", int'(tx_fifo_wr), 1);
        cyc(); tx_wr = 1'b0;
        // R12 set and clear in the same cycle
        clr_we = 1'b1; clr_data = 5'h10; tx_full = 1'b1; tx_wr = 1'b1;
        cyc();
        tx_full = 1'b0; tx_wr = 1'b0;
        chk("R12 set wins", int'(status[4]), 1);
        cyc(); clr_we = 1'b0; clr_data = 5'h00;
        chk("R11 clear after collision", int'(status[4]), 0);

        // R11 write-1 clear walk
        set_all();
        chk("R11 all set", int'(status), 31);
        clr_we = 1'b1; clr_data = 5'h00; cyc();
        chk("R11 zero write no effect", int'(status), 31);
        begin
            int expv = 31;
            for (int b = 1; b <= 4; b++) begin
                clr_data = 5'(1 << b); cyc();
                expv = expv & ~(1 << b);
                chk("R11 clear one bit", int'(status), expv);
            end
        end
        clr_data = 5'h01; cyc();
        chk("R11 block flag not write-clearable", int'(status), 1);
        clr_we = 1'b0; clr_data = 5'h00;

        // R14 mask sweep
        set_all();
        for (int m = 0; m < 32; m++) begin
            irq_mask = 5'(m);
            #1 chk("R14 all flags", int'(irq), (((~m) & 31) != 0) ? 1 : 0);
            cyc();
        end
        clr_we = 1'b1; clr_data = 5'h1E; cyc(); clr_we = 1'b0; clr_data = 5'h00;
        for (int m = 0; m < 32; m++) begin
            irq_mask = 5'(m);
            #1 chk("R14 block flag only", int'(irq), (m % 2 == 0) ? 1 : 0);
            cyc();
        end
        irq_mask = 5'h00;
        srst();
        chk("R13 all cleared", int'(status), 0);
        chk("R14 idle irq", int'(irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule